// File: doc/BRIEF.md
# SPI Slave Hold Condition Controller

This block sits at the front of a serial memory slave and decides when a transfer is paused. It samples the active-low chip enable, the serial clock and an active-low pause input on a fast system clock. It then keeps a pause flag. While the flag is set, the receive shifter and its bit counter hold their values and the serial output driver is switched off. A master can therefore freeze a transfer in the middle of a byte and continue it later from the same bit.

Entering and leaving the pause is tied to the low phase of the serial clock. The serial clock runs in mode 0: it idles low, and data is taken on the rising edge. A change on the pause input while the clock is low takes effect at once. A change while the clock is high waits until the clock next goes low. Raising chip enable at any time returns the slave to standby. This clears the pause, the bit position and any partial byte. A small receive shifter is included so that the pause behaviour can be observed at the ports.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, hold_active, so_oe and rx_valid are all 0.
- R2: While ce_n is high, hold_n has no effect and hold_active stays 0, whatever sck does.
- R3: If hold_n falls while ce_n is low and sck is low, hold_active becomes 1 within 3 clk cycles.
- R4: If hold_n falls while sck is high, hold_active stays 0 until sck goes low, and becomes 1 within 3 clk cycles after that.
- R5: If hold_n rises while sck is low, hold_active returns to 0 within 3 clk cycles. If it rises while sck is high, hold_active stays 1 until sck goes low.
- R6: While hold_active is 1, so_oe and shift_en are 0, and toggling sck and si changes no received data.
- R7: While hold_n stays low and ce_n stays low, hold_active stays 1 through any number of sck toggles.
- R8: When the pause ends, reception continues from the same bit position. The byte reported equals the bits sent outside the pause.
- R9: ce_n going high clears hold_active, the bit position and any partial byte. If hold_n is still low when ce_n falls again, the slave re-enters the pause while sck is low.
- R10: so_oe is 1 exactly when ce_n is low and no pause is active (after synchronizer delay).
- R11: si is taken on each rising sck edge, most significant bit first. rx_valid pulses for one clk cycle with rx_data holding the byte after the eighth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the sck rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable from the master |
| sck | input | 1 | Serial clock, mode 0 |
| hold_n | input | 1 | Active-low pause request |
| si | input | 1 | Serial data in |
| hold_active | output | 1 | Pause is in force |
| shift_en | output | 1 | One-cycle qualifier for an accepted rising sck edge |
| so_oe | output | 1 | Output enable for the serial data out driver |
| rx_data | output | 8 | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe when rx_data is updated |

## Verification
The pause input is moved in four phase combinations: falling and rising, each with sck low and with sck high. This separates immediate entry and exit from deferred entry and exit. Pauses are placed in the middle of bytes with junk clocks and data applied during the pause. The resulting bytes, compared through a scoreboard, show whether any bit was lost, duplicated or taken in the wrong order. Chip-enable aborts show three things: a partial byte is discarded, a pause is dropped at standby, and a pause is re-entered when enable returns while the pause input is still low.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  localparam int unsigned WORD_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } hold_state_e;

  // Pause state update, evaluated each system clock on synchronized levels.
  // Decisions are only taken while the serial clock is low.
  function automatic hold_state_e hold_next(input logic ce_n_s,
                                            input logic sck_s,
                                            input logic hold_n_s,
                                            input hold_state_e cur);
    hold_state_e nxt;
    if (ce_n_s)          nxt = ST_IDLE;
    else if (!sck_s)     nxt = hold_n_s ? ST_RUN : ST_HOLD;
    else if (cur == ST_IDLE) nxt = ST_RUN;
    else                 nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic hold_active,
  output logic running
);

  hold_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= hold_next(ce_n_s, sck_s, hold_n_s, state_q);
  end

  assign hold_active = (state_q == ST_HOLD);
  assign running     = (state_q == ST_RUN);

  // R2: standby whenever chip enable is high
  p_idle_no_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_s |=> !hold_active);

  // R3: pause request seen with clock low takes effect next cycle
  p_enter_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_s && !sck_s && !hold_n_s) |=> hold_active);

  // R4 / R5: with the clock high the pause flag never changes
  p_defer_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_s && sck_s) |=> $stable(hold_active));

  // R7: pause persists while the request stays low
  p_stay_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !ce_n_s && !hold_n_s) |=> hold_active);

endmodule

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);

  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     shreg_q;
  logic             last_bit;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == LAST) ? '0 : c + CNT_W'(1);
  endfunction

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] s, input logic b);
    return {s[W-2:0], b};
  endfunction

  assign last_bit = shift_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shreg_q  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (clear) begin
        cnt_q   <= '0;
        shreg_q <= '0;
      end else if (shift_en) begin
        cnt_q   <= cnt_step(cnt_q);
        shreg_q <= shift_in(shreg_q, din);
        if (last_bit) begin
          rx_data  <= shift_in(shreg_q, din);
          rx_valid <= 1'b1;
        end
      end
    end
  end

  // R9: standby clears the bit position
  p_clear_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  // R8: without an accepted edge the position is kept
  p_keep_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clear) |=> $stable(cnt_q) && $stable(shreg_q));

  // R11: a byte strobe follows only the last bit position
  p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(shift_en) && ($past(cnt_q) == LAST));

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              sck,
  input  logic              hold_n,
  input  logic              si,
  output logic              hold_active,
  output logic              shift_en,
  output logic              so_oe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  logic [3:0] raw_in;
  logic [3:0] syn_in;
  logic       ce_n_s, hold_n_s, sck_s, si_s;
  logic       sck_q;
  logic       sck_rise;
  logic       running;

  assign raw_in = {ce_n, hold_n, sck, si};

  spi_hold_sync #(
    .W      (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (syn_in)
  );

  assign {ce_n_s, hold_n_s, sck_s, si_s} = syn_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sck_rise = sck_s && !sck_q;

  spi_hold_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n_s     (ce_n_s),
    .sck_s      (sck_s),
    .hold_n_s   (hold_n_s),
    .hold_active(hold_active),
    .running    (running)
  );

  assign shift_en = sck_rise && running;
  assign so_oe    = running;

  spi_hold_shifter #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ce_n_s),
    .shift_en(shift_en),
    .din     (si_s),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );

  // R6: a pause silences the driver and the shifter
  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (!so_oe && !shift_en));

  // R10: driver off whenever chip enable is high
  p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_s |=> !so_oe);

  // R5: pause leaves only while the clock is low
  p_exit_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> (!$past(sck_s) || $past(ce_n_s)));

endmodule

// File: tb/spi_hold_ctrl_bench.sv
`timescale 1ns/1ps
module spi_hold_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
  logic       hold_active, shift_en, so_oe, rx_valid;
  logic [7:0] rx_data;

  int n_chk = 0, n_bad = 0;
  int held_shifts = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  spi_hold_ctrl u_spi_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sck(sck), .hold_n(hold_n),
    .si(si), .hold_active(hold_active), .shift_en(shift_en), .so_oe(so_oe),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one mode-0 bit: data set with clock low, rising edge, back low
  task automatic send_bit(input logic b);
    si = b; wt(4);
    sck = 1'b1; wt(4);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    exp_q.push_back(v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    wt(4);
  endtask

  // monitor: scoreboard compare on each byte strobe, plus pause sanity
  initial begin
    forever begin
      @(negedge clk);
      if (hold_active && shift_en) held_shifts++;
      if (rx_valid) begin
        if (exp_q.size() == 0) chk("R11 unexpected byte", {24'd0, rx_data}, 32'hFFFF);
        else chk("R8/R11 byte", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wt(3);
    chk("R1 hold_active", hold_active, 0);
    chk("R1 so_oe", so_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    rst_n = 1'b1; wt(4);

    // R2: pause ignored in standby
    hold_n = 1'b0; wt(4);
    sck = 1'b1; wt(4); sck = 1'b0; wt(4);
    chk("R2 ignored in standby", hold_active, 0);
    chk("R10 oe off in standby", so_oe, 0);
    hold_n = 1'b1; wt(4);

    // R11: plain byte
    ce_n = 1'b0; wt(4);
    chk("R10 oe on when selected", so_oe, 1);
    send_byte(8'hA5);

    // R3/R5/R6/R7/R8: immediate pause in middle of 0xC3
    exp_q.push_back(8'hC3);
    send_bit(1); send_bit(1); send_bit(0);
    wt(2);
    hold_n = 1'b0; wt(4);
    chk("R3 immediate entry", hold_active, 1);
    chk("R6 oe off in pause", so_oe, 0);
    for (int k = 0; k < 3; k++) send_bit(k[0]);
    wt(2);
    chk("R7 pause persists", hold_active, 1);
    hold_n = 1'b1; wt(4);
    chk("R5 immediate exit", hold_active, 0);
    send_bit(0); send_bit(0); send_bit(0); send_bit(1); send_bit(1);
    wt(4);

    // R4/R5 deferred: 0x5A = 0101_1010
    exp_q.push_back(8'h5A);
    send_bit(0); send_bit(1);
    si = 1'b0; wt(4); sck = 1'b1; wt(2);
    hold_n = 1'b0; wt(4);
    chk("R4 no entry while sck high", hold_active, 0);
    sck = 1'b0; wt(4);
    chk("R4 entry at sck low", hold_active, 1);
    si = 1'b1; sck = 1'b1; wt(2);
    hold_n = 1'b1; wt(4);
    chk("R5 no exit while sck high", hold_active, 1);
    sck = 1'b0; wt(4);
    chk("R5 exit at sck low", hold_active, 0);
    send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    wt(4);

    // R9: abort partial byte
    send_bit(1); send_bit(1); send_bit(1);
    ce_n = 1'b1; wt(6);
    ce_n = 1'b0; wt(4);
    send_byte(8'h3C);

    // R9: chip enable high during pause, then re-entry with hold low
    send_bit(1); send_bit(0);
    hold_n = 1'b0; wt(4);
    chk("R9 paused before abort", hold_active, 1);
    ce_n = 1'b1; wt(4);
    chk("R9 standby clears pause", hold_active, 0);
    chk("R9 oe off in standby", so_oe, 0);
    ce_n = 1'b0; wt(4);
    chk("R9 re-entry while hold low", hold_active, 1);
    hold_n = 1'b1; wt(4);
    chk("R9 resume", hold_active, 0);
    send_byte(8'h96);

    chk("R6 no shift in pause", held_shifts, 0);
    chk("R8 all bytes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule